// File: doc/BRIEF.md
# Station Address Match Filter

This block decides, frame by frame, whether a receive path should keep an incoming frame. It holds a table of sixteen 48-bit station addresses with a 16-bit participation mask, and a short set of mode bits decides how runt frames, group addresses and the all-ones destination are treated. The receive logic presents the destination address and the frame length (FCS excluded) with a one-cycle compare strobe. One cycle later it gets a registered verdict: keep or drop, plus a broadcast flag and a multicast flag.

Software fills the table without touching it directly. It sets up a list of 4-word descriptors in memory and issues a load command with a word pointer and a descriptor count. The block then walks the list over a word-read port that allows one read in flight, and fills consecutive slots starting at slot 0. It fetches one more word as the participation mask and then reports completion with a one-cycle pulse. While the surrounding device is held in its reset mode, any slot can be read back as three 16-bit byte pairs for diagnostics.

Top module: `station_match_filter`

## Requirements
- R1: After `rst`, `res_valid`, `res_accept`, `res_bcast`, `res_mcast`, `load_busy`, `load_done` and `mem_req` are 0. Every table slot reads back as zero and the participation mask is empty.
- R2: A verdict appears with `res_valid` high exactly one cycle after a cycle with `cmp_strobe` high. `res_valid` is low in every other cycle, and the verdict outputs hold their value until the next strobe.
- R3: A frame with `cmp_len` below 60 is dropped when `mode_runt_ok` is 0. It is kept with both flags clear when `mode_runt_ok` is 1, whatever the other modes and the address are.
- R4: With `mode_promisc` set, a non-runt frame whose first destination byte (`cmp_dst[7:0]`) has bit 0 clear (bit 0 of `cmp_dst`) is kept with no flag. A destination with that bit set is not kept by this rule.
- R5: With `mode_all_mcast` set, a non-runt frame whose destination has bit 0 of its first byte set is kept with `res_mcast` set. This rule wins over the broadcast rule.
- R6: With `mode_bcast_ok` set, and when no earlier rule decided, an all-ones destination is kept with `res_bcast` set.
- R7: Otherwise, a non-runt frame is kept with no flag when its destination equals a table slot whose mask bit is set. A slot whose mask bit is clear never matches.
- R8: A non-runt frame that no rule keeps is dropped with both flags clear.
- R9: A load command reads, for each of `load_count` descriptors (5-bit count), the words at pointer+1, pointer+2 and pointer+3 in that order. These are the slot's byte pairs 0, 1 and 2, low byte first, so byte 0 of a pair word is bits 7:0. The pointer then advances by 4 words, and slots fill from 0 upward.
- R10: After the last descriptor (or at once when the count is 0), one word is read at the advanced pointer and becomes the participation mask, with bit i enabling slot i. `load_done` pulses for one cycle in the cycle after that response, and `load_busy` is low from then on.
- R11: While `cfg_reset_mode` is 1, `rb_pair0`, `rb_pair1` and `rb_pair2` show byte pairs 0, 1 and 2 of the slot chosen by `rb_slot`. While it is 0, all three are zero.
- R12: A `load_start` that arrives while a load is in progress is ignored. The read sequence and the single completion pulse of the running load are unchanged.
- R13: `mem_req` is a one-cycle pulse issued only while `load_busy` is high, and no new request is issued until the previous read has returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_reset_mode | input | 1 | Device is in its reset mode; enables slot readback |
| mode_runt_ok | input | 1 | Keep frames shorter than 60 bytes |
| mode_promisc | input | 1 | Keep every individual (non-group) destination |
| mode_all_mcast | input | 1 | Keep every group destination, flagged multicast |
| mode_bcast_ok | input | 1 | Keep the all-ones destination, flagged broadcast |
| cmp_strobe | input | 1 | Evaluate the presented frame this cycle |
| cmp_dst | input | 48 | Destination address, first byte in bits 7:0 |
| cmp_len | input | 16 | Frame length in bytes, FCS excluded |
| res_valid | output | 1 | Verdict valid (one cycle after strobe) |
| res_accept | output | 1 | Frame is kept |
| res_bcast | output | 1 | Kept by the broadcast rule |
| res_mcast | output | 1 | Kept by the all-multicast rule |
| load_start | input | 1 | Start a table load |
| load_ptr | input | 16 | Word address of the first descriptor |
| load_count | input | 5 | Number of descriptors to read |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 16 | Word address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| load_busy | output | 1 | Load in progress |
| load_done | output | 1 | One-cycle load completion pulse |
| rb_slot | input | 4 | Slot selected for readback |
| rb_pair0 | output | 16 | Bytes 1:0 of the selected slot |
| rb_pair1 | output | 16 | Bytes 3:2 of the selected slot |
| rb_pair2 | output | 16 | Bytes 5:4 of the selected slot |

## Verification
The hardest situation to reach from the ports is a stale slot. Such a slot still holds a valid address, but a later load has cleared its mask bit and did not overwrite it, so it must stop matching. A second short load that rewrites only the lower slots with a mask excluding slot 2 produces this case. A third load with a zero count then re-enables slot 2 through the mask word alone. A load command is also injected in the middle of a load, and the randomly delayed read responses are logged, so the address order and the single completion pulse show that the command was ignored. Random frames are drawn from loaded slots, stale slots, the all-ones address, group addresses and random addresses, under random modes and lengths around the 60-byte limit, so that every priority rule takes part.

// File: rtl/saf_pkg.sv
package saf_pkg;
    localparam int SLOTS      = 16;
    localparam int SLOT_W     = $clog2(SLOTS);
    localparam int WORD_W     = 16;
    localparam int PAIRS      = 3;
    localparam int PAIR_W     = $clog2(PAIRS);
    localparam int MAC_W      = WORD_W * PAIRS;
    localparam int MADDR_W    = 16;
    localparam int LEN_W      = 16;
    localparam int CNT_W      = 5;
    localparam int DESC_WORDS = 4;
    localparam int RUNT_MIN   = 60;

    typedef logic [MAC_W-1:0] mac_t;

    typedef struct packed {
        logic accept;
        logic bcast;
        logic mcast;
    } verdict_t;

    typedef struct packed {
        logic runt_ok;
        logic promisc;
        logic all_mcast;
        logic bcast_ok;
    } rx_mode_t;

    typedef enum logic [1:0] {
        LD_IDLE,
        LD_ISSUE,
        LD_WAIT
    } ld_state_e;

    function automatic logic is_group(mac_t a);
        return a[0];
    endfunction

    function automatic logic is_all_ones(mac_t a);
        return &a;
    endfunction
endpackage

// File: rtl/saf_cam_store.sv
module saf_cam_store
    import saf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [PAIR_W-1:0] wr_pair,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              mask_we,
    input  logic [SLOTS-1:0]  mask_data,
    output mac_t              entries [SLOTS],
    output logic [SLOTS-1:0]  enable_mask
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_slot == SLOT_W'(s));
        for (genvar p = 0; p < PAIRS; p++) begin : g_pair
            always_ff @(posedge clk) begin
                if (rst) begin
                    entries[s][p*WORD_W +: WORD_W] <= '0;
                end else if (sel && (wr_pair == PAIR_W'(p))) begin
                    entries[s][p*WORD_W +: WORD_W] <= wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_mask <= '0;
        end else if (mask_we) begin
            enable_mask <= mask_data;
        end
    end
endmodule

// File: rtl/saf_loader.sv
module saf_loader
    import saf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [MADDR_W-1:0] start_ptr,
    input  logic [CNT_W-1:0]   start_count,
    output logic               mem_req,
    output logic [MADDR_W-1:0] mem_addr,
    input  logic               mem_rvalid,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               wr_en,
    output logic [SLOT_W-1:0]  wr_slot,
    output logic [PAIR_W-1:0]  wr_pair,
    output logic [WORD_W-1:0]  wr_data,
    output logic               mask_we,
    output logic [SLOTS-1:0]   mask_data,
    output logic               busy,
    output logic               done
);
    ld_state_e          state;
    logic [MADDR_W-1:0] ptr;
    logic [CNT_W-1:0]   cnt;
    logic [SLOT_W-1:0]  slot;
    logic [PAIR_W-1:0]  wsel;
    logic               mask_ph;
    logic               resp;

    assign resp = (state == LD_WAIT) && mem_rvalid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= LD_IDLE;
            ptr     <= '0;
            cnt     <= '0;
            slot    <= '0;
            wsel    <= '0;
            mask_ph <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                LD_IDLE: begin
                    if (start) begin
                        ptr     <= start_ptr;
                        cnt     <= start_count;
                        slot    <= '0;
                        wsel    <= '0;
                        mask_ph <= (start_count == '0);
                        state   <= LD_ISSUE;
                    end
                end
                LD_ISSUE: state <= LD_WAIT;
                LD_WAIT: begin
                    if (mem_rvalid) begin
                        if (mask_ph) begin
                            state <= LD_IDLE;
                            done  <= 1'b1;
                        end else if (wsel == PAIR_W'(PAIRS-1)) begin
                            wsel    <= '0;
                            slot    <= slot + SLOT_W'(1);
                            cnt     <= cnt - CNT_W'(1);
                            ptr     <= ptr + MADDR_W'(DESC_WORDS);
                            mask_ph <= (cnt == CNT_W'(1));
                            state   <= LD_ISSUE;
                        end else begin
                            wsel  <= wsel + PAIR_W'(1);
                            state <= LD_ISSUE;
                        end
                    end
                end
                default: state <= LD_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = (state == LD_ISSUE);
        mem_addr  = mask_ph ? ptr : (ptr + MADDR_W'(wsel) + MADDR_W'(1));
        wr_en     = resp && !mask_ph;
        wr_slot   = slot;
        wr_pair   = wsel;
        wr_data   = mem_rdata;
        mask_we   = resp && mask_ph;
        mask_data = mem_rdata[SLOTS-1:0];
        busy      = (state != LD_IDLE);
    end
endmodule

// File: rtl/saf_match_eval.sv
module saf_match_eval
    import saf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  mac_t             dst,
    input  logic [LEN_W-1:0] len,
    input  rx_mode_t         mode,
    input  mac_t             entries [SLOTS],
    input  logic [SLOTS-1:0] enable_mask,
    output logic             valid,
    output verdict_t         verdict
);
    logic [SLOTS-1:0] hit;
    verdict_t         next_v;

    for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
        assign hit[s] = enable_mask[s] && (entries[s] == dst);
    end

    always_comb begin
        next_v = '0;
        if (len < LEN_W'(RUNT_MIN)) begin
            next_v.accept = mode.runt_ok;
        end else if (mode.promisc && !is_group(dst)) begin
            next_v.accept = 1'b1;
        end else if (mode.all_mcast && is_group(dst)) begin
            next_v.accept = 1'b1;
            next_v.mcast  = 1'b1;
        end else if (mode.bcast_ok && is_all_ones(dst)) begin
            next_v.accept = 1'b1;
            next_v.bcast  = 1'b1;
        end else begin
            next_v.accept = |hit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid   <= 1'b0;
            verdict <= '0;
        end else begin
            valid <= strobe;
            if (strobe) begin
                verdict <= next_v;
            end
        end
    end
endmodule

// File: rtl/station_match_filter.sv
module station_match_filter
    import saf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_reset_mode,
    input  logic               mode_runt_ok,
    input  logic               mode_promisc,
    input  logic               mode_all_mcast,
    input  logic               mode_bcast_ok,
    input  logic               cmp_strobe,
    input  logic [MAC_W-1:0]   cmp_dst,
    input  logic [LEN_W-1:0]   cmp_len,
    output logic               res_valid,
    output logic               res_accept,
    output logic               res_bcast,
    output logic               res_mcast,
    input  logic               load_start,
    input  logic [MADDR_W-1:0] load_ptr,
    input  logic [CNT_W-1:0]   load_count,
    output logic               mem_req,
    output logic [MADDR_W-1:0] mem_addr,
    input  logic               mem_rvalid,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               load_busy,
    output logic               load_done,
    input  logic [SLOT_W-1:0]  rb_slot,
    output logic [WORD_W-1:0]  rb_pair0,
    output logic [WORD_W-1:0]  rb_pair1,
    output logic [WORD_W-1:0]  rb_pair2
);
    mac_t              entries [SLOTS];
    logic [SLOTS-1:0]  enable_mask;
    logic              wr_en;
    logic [SLOT_W-1:0] wr_slot;
    logic [PAIR_W-1:0] wr_pair;
    logic [WORD_W-1:0] wr_data;
    logic              mask_we;
    logic [SLOTS-1:0]  mask_data;
    rx_mode_t          mode;
    verdict_t          verdict;
    mac_t              rb_entry;

    assign mode = '{runt_ok:   mode_runt_ok,
                    promisc:   mode_promisc,
                    all_mcast: mode_all_mcast,
                    bcast_ok:  mode_bcast_ok};

    saf_loader u_loader (
        .clk        (clk),
        .rst        (rst),
        .start      (load_start),
        .start_ptr  (load_ptr),
        .start_count(load_count),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot),
        .wr_pair    (wr_pair),
        .wr_data    (wr_data),
        .mask_we    (mask_we),
        .mask_data  (mask_data),
        .busy       (load_busy),
        .done       (load_done)
    );

    saf_cam_store u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot),
        .wr_pair    (wr_pair),
        .wr_data    (wr_data),
        .mask_we    (mask_we),
        .mask_data  (mask_data),
        .entries    (entries),
        .enable_mask(enable_mask)
    );

    saf_match_eval u_eval (
        .clk        (clk),
        .rst        (rst),
        .strobe     (cmp_strobe),
        .dst        (cmp_dst),
        .len        (cmp_len),
        .mode       (mode),
        .entries    (entries),
        .enable_mask(enable_mask),
        .valid      (res_valid),
        .verdict    (verdict)
    );

    assign res_accept = verdict.accept;
    assign res_bcast  = verdict.bcast;
    assign res_mcast  = verdict.mcast;

    assign rb_entry = entries[rb_slot];
    assign rb_pair0 = cfg_reset_mode ? rb_entry[0*WORD_W +: WORD_W] : '0;
    assign rb_pair1 = cfg_reset_mode ? rb_entry[1*WORD_W +: WORD_W] : '0;
    assign rb_pair2 = cfg_reset_mode ? rb_entry[2*WORD_W +: WORD_W] : '0;
endmodule

// File: rtl/saf_checker.sv
module saf_checker
    import saf_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               cfg_reset_mode,
    input logic               mode_runt_ok,
    input logic               cmp_strobe,
    input logic [LEN_W-1:0]   cmp_len,
    input logic               res_valid,
    input logic               res_accept,
    input logic               res_bcast,
    input logic               res_mcast,
    input logic               mem_req,
    input logic               load_busy,
    input logic               load_done,
    input logic [WORD_W-1:0]  rb_pair0,
    input logic [WORD_W-1:0]  rb_pair1,
    input logic [WORD_W-1:0]  rb_pair2
);
    // R2
    strobe_result_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_strobe |=> res_valid);

    // R2
    no_strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cmp_strobe |=> !res_valid);

    // R3
    runt_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_strobe && (cmp_len < LEN_W'(RUNT_MIN)) && !mode_runt_ok) |=> !res_accept);

    // R3
    runt_noflag_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_strobe && (cmp_len < LEN_W'(RUNT_MIN))) |=> (!res_bcast && !res_mcast));

    // R5
    flag_needs_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (res_bcast || res_mcast) |-> res_accept);

    // R13
    req_in_load_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> load_busy);

    // R13
    single_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R10
    done_ends_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_done |-> (!load_busy && $past(load_busy)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        load_done |=> !load_done);

    // R11
    readback_off_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_reset_mode |-> (rb_pair0 == '0 && rb_pair1 == '0 && rb_pair2 == '0));
endmodule

bind station_match_filter saf_checker u_saf_checker (
    .clk           (clk),
    .rst           (rst),
    .cfg_reset_mode(cfg_reset_mode),
    .mode_runt_ok  (mode_runt_ok),
    .cmp_strobe    (cmp_strobe),
    .cmp_len       (cmp_len),
    .res_valid     (res_valid),
    .res_accept    (res_accept),
    .res_bcast     (res_bcast),
    .res_mcast     (res_mcast),
    .mem_req       (mem_req),
    .load_busy     (load_busy),
    .load_done     (load_done),
    .rb_pair0      (rb_pair0),
    .rb_pair1      (rb_pair1),
    .rb_pair2      (rb_pair2)
);

// File: tb/tb_station_match_filter.sv
module tb_station_match_filter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_reset_mode = 1'b1;
    logic        mode_runt_ok = 0, mode_promisc = 0, mode_all_mcast = 0, mode_bcast_ok = 0;
    logic        cmp_strobe = 0;
    logic [47:0] cmp_dst = '0;
    logic [15:0] cmp_len = '0;
    logic        res_valid, res_accept, res_bcast, res_mcast;
    logic        load_start = 0;
    logic [15:0] load_ptr = '0;
    logic [4:0]  load_count = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_rvalid = 0;
    logic [15:0] mem_rdata = '0;
    logic        load_busy, load_done;
    logic [3:0]  rb_slot = '0;
    logic [15:0] rb_pair0, rb_pair1, rb_pair2;

    station_match_filter dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [15:0] bmem [256];
    logic [47:0] tb_cam [16];
    logic [15:0] tb_mask;

    logic [15:0] req_log [64];
    int          nreq = 0;
    int          ndone = 0;
    logic [15:0] pend_addr = '0;
    int          pend_cnt = 0;

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (pend_cnt > 0) begin
            pend_cnt <= pend_cnt - 1;
            if (pend_cnt == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= bmem[pend_addr[7:0]];
            end
        end
        if (mem_req) begin
            pend_addr <= mem_addr;
            pend_cnt  <= 1 + int'($urandom % 3);
            if (nreq < 64) req_log[nreq] <= mem_addr;
            nreq <= nreq + 1;
        end
        if (load_done) ndone <= ndone + 1;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] model(input logic [47:0] d, input logic [15:0] len,
                                         input logic [3:0] m);
        logic hit = 1'b0;
        for (int i = 0; i < 16; i++)
            if (tb_mask[i] && tb_cam[i] == d) hit = 1'b1;
        if (len < 16'd60)             return m[3] ? 3'b100 : 3'b000;
        if (m[2] && !d[0])            return 3'b100;
        if (m[1] && d[0])             return 3'b101;
        if (m[0] && (&d))             return 3'b110;
        if (hit)                      return 3'b100;
        return 3'b000;
    endfunction

    task automatic frame(input logic [47:0] d, input logic [15:0] len, input logic [3:0] m,
                         input string req, input bit check_hold);
        logic [2:0] exp;
        exp = model(d, len, m);
        @(negedge clk);
        {mode_runt_ok, mode_promisc, mode_all_mcast, mode_bcast_ok} = m;
        cmp_dst = d; cmp_len = len; cmp_strobe = 1'b1;
        @(negedge clk);
        cmp_strobe = 1'b0;
        cmp_dst = ~d; cmp_len = 16'd0;
        check(res_valid === 1'b1, "R2", 64'(res_valid), 64'd1);
        check({res_accept, res_bcast, res_mcast} === exp, req,
              64'({res_accept, res_bcast, res_mcast}), 64'(exp));
        if (check_hold) begin
            @(negedge clk);
            check(res_valid === 1'b0 && {res_accept, res_bcast, res_mcast} === exp, "R2",
                  64'({res_valid, res_accept, res_bcast, res_mcast}), 64'(exp));
        end
    endtask

    task automatic fill_desc(input int base, input int n, input logic [15:0] mask_word,
                             input int first_slot);
        for (int k = 0; k < n; k++) begin
            logic [47:0] e;
            e = {16'($urandom), 16'($urandom), 16'($urandom)};
            bmem[(base + 4*k) & 255]     = 16'hDEAD;
            bmem[(base + 4*k + 1) & 255] = e[15:0];
            bmem[(base + 4*k + 2) & 255] = e[31:16];
            bmem[(base + 4*k + 3) & 255] = e[47:32];
            tb_cam[(first_slot + k) % 16] = e;
        end
        bmem[(base + 4*n) & 255] = mask_word;
        tb_mask = mask_word;
    endtask

    task automatic run_load(input int base, input int n, input bit poke_busy, input string req);
        int start_req, start_done, guard;
        start_req = nreq; start_done = ndone;
        @(negedge clk);
        load_ptr = 16'(base); load_count = 5'(n); load_start = 1'b1;
        @(negedge clk);
        load_start = 1'b0;
        check(load_busy === 1'b1, req, 64'(load_busy), 64'd1);
        if (poke_busy) begin
            repeat (4) @(negedge clk);
            load_ptr = 16'h0080; load_count = 5'd7; load_start = 1'b1;   // R12 stray command
            @(negedge clk);
            load_start = 1'b0;
        end
        guard = 0;
        while (load_busy === 1'b1 && guard < 2000) begin @(negedge clk); guard++; end
        check(load_done === 1'b1, "R10", 64'(load_done), 64'd1);
        @(negedge clk);
        check(load_done === 1'b0 && load_busy === 1'b0, "R10", 64'({load_done, load_busy}), 64'd0);
        repeat (8) @(negedge clk);
        check(ndone - start_done == 1, "R12", 64'(ndone - start_done), 64'd1);
        check(nreq - start_req == 3*n + 1, "R13", 64'(nreq - start_req), 64'(3*n + 1));
        for (int k = 0; k < n; k++)
            for (int w = 0; w < 3; w++)
                check(req_log[start_req + 3*k + w] == 16'(base + 4*k + w + 1), "R9",
                      64'(req_log[start_req + 3*k + w]), 64'(base + 4*k + w + 1));
        check(req_log[start_req + 3*n] == 16'(base + 4*n), "R10",
              64'(req_log[start_req + 3*n]), 64'(base + 4*n));
    endtask

    task automatic check_readback(input int upto);
        cfg_reset_mode = 1'b1;
        for (int s = 0; s < upto; s++) begin
            @(negedge clk);
            rb_slot = 4'(s);
            #1;
            check({rb_pair2, rb_pair1, rb_pair0} === tb_cam[s], "R11",
                  64'({rb_pair2, rb_pair1, rb_pair0}), 64'(tb_cam[s]));
        end
        @(negedge clk);
        cfg_reset_mode = 1'b0;
        #1;
        check({rb_pair2, rb_pair1, rb_pair0} === 48'd0, "R11",
              64'({rb_pair2, rb_pair1, rb_pair0}), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) bmem[i] = 16'(i * 16'h0101);
        for (int i = 0; i < 16; i++) tb_cam[i] = '0;
        tb_mask = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check({res_valid, res_accept, res_bcast, res_mcast, load_busy, load_done, mem_req} === 7'd0,
              "R1", 64'({res_valid, res_accept, res_bcast, res_mcast, load_busy, load_done, mem_req}), 64'd0);
        check_readback(16);
        frame(48'h00_00_00_00_00_00, 16'd64, 4'b0000, "R1", 1'b0);   // all-zero slots disabled

        // Load 1: three descriptors, slots 0 and 2 enabled, stray command mid-load
        fill_desc(32, 3, 16'h0005, 0);
        tb_cam[1][0] = 1'b0; bmem[33][0] = 1'b0;
        tb_cam[0][0] = 1'b0; bmem[33-4+4][0] = 1'b0;
        tb_cam[0] = {bmem[35], bmem[34], bmem[33]};
        tb_cam[2][0] = 1'b0; bmem[41][0] = 1'b0;
        tb_cam[2] = {bmem[43], bmem[42], bmem[41]};
        tb_cam[1] = {bmem[39], bmem[38], bmem[37]};
        run_load(32, 3, 1'b1, "R9");
        check_readback(3);

        // Directed priority cases
        frame(tb_cam[0], 16'd59, 4'b0000, "R3", 1'b1);
        frame(48'hFFFF_FFFF_FFFF, 16'd20, 4'b1111, "R3", 1'b0);
        frame(tb_cam[0], 16'd60, 4'b0000, "R7", 1'b1);
        frame(tb_cam[2], 16'd100, 4'b0000, "R7", 1'b0);
        frame(tb_cam[1], 16'd100, 4'b0000, "R7", 1'b0);           // disabled slot
        frame(48'h1234_5678_9A02, 16'd80, 4'b0100, "R4", 1'b0);
        frame(48'h1234_5678_9A03, 16'd80, 4'b0100, "R4", 1'b0);   // group not covered
        frame(48'h1234_5678_9A03, 16'd80, 4'b0010, "R5", 1'b0);
        frame(48'hFFFF_FFFF_FFFF, 16'd80, 4'b0011, "R5", 1'b0);   // multicast wins
        frame(48'hFFFF_FFFF_FFFF, 16'd80, 4'b0001, "R6", 1'b1);
        frame(48'hFFFF_FFFF_FFFF, 16'd80, 4'b0000, "R8", 1'b0);
        frame(48'h0000_0000_0042, 16'd80, 4'b0000, "R8", 1'b0);

        // Load 2: two descriptors, slot 2 becomes stale (mask 0x0003)
        fill_desc(64, 2, 16'h0003, 0);
        run_load(64, 2, 1'b0, "R9");
        frame(tb_cam[2], 16'd70, 4'b0000, "R7", 1'b0);
        frame(tb_cam[1], 16'd70, 4'b0000, "R7", 1'b0);

        // Load 3: zero count, mask only re-enables slot 2
        bmem[96] = 16'h0007; tb_mask = 16'h0007;
        run_load(96, 0, 1'b0, "R10");
        frame(tb_cam[2], 16'd70, 4'b0000, "R7", 1'b0);
        check_readback(3);

        // Random frames
        for (int n = 0; n < 400; n++) begin
            logic [47:0] d;
            logic [3:0]  m;
            logic [15:0] len;
            int          sel;
            sel = int'($urandom % 5);
            case (sel)
                0: d = tb_cam[$urandom % 3];
                1: d = 48'hFFFF_FFFF_FFFF;
                2: d = {16'($urandom), 16'($urandom), 16'($urandom)} | 48'd1;
                default: d = {16'($urandom), 16'($urandom), 16'($urandom)};
            endcase
            m   = 4'($urandom);
            len = 16'(40 + $urandom % 60);
            frame(d, len, m, "R8", (n % 7) == 0);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule